// File: doc/BRIEF.md
# Autovectored Interrupt Vector Substitution

This block gathers fourteen FIFO-flag and waveform-engine interrupt sources onto one shared CPU interrupt request. Every source owns a pending bit, set by a one-cycle pulse and cleared by software through a write-one-to-clear strobe. It also owns an enable bit that decides whether a pending bit may raise the request. A fixed-priority encoder picks the winning source, and the block turns its position into a vector byte.

When the CPU takes the interrupt, it pushes its program counter and jumps to code address 0x553. Software has placed a jump opcode there and the page byte of a jump table at 0x554. With autovectoring enabled, the block watches the instruction-fetch path. When the CPU fetches 0x555, the block replaces the stored memory byte with the vector byte, so the jump lands on the entry for that source. The vector is captured when the CPU acknowledges the interrupt. It is then held until the 0x555 fetch has finished, so a late, higher-priority source cannot tear the jump target.

The fetch path is a plain timed path with no handshake and no back-pressure. The override is combinational: `fetch_data` is valid in the same cycle that `fetch_valid`, `fetch_addr` and `mem_rdata` are presented. The register-write strobes and the acknowledge are single-cycle control pulses.

Top module: `avec_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[i]` sets `pend_o[i]` at the next clock edge, whether or not the source is enabled.
- R2: With `clr_wr` high, every bit set in `clr_mask` clears the matching pending bit at the next edge. Bits that are zero in the mask are left unchanged.
- R3: If `src_pulse[i]` and a clear of bit i arrive in the same cycle, the pending bit is 1 after the edge.
- R4: `irq` is high exactly when some pending bit has its enable bit set. It falls in the cycle right after the edge that clears the last enabled pending bit. `en_wr` loads `en_wdata` into `en_o` at the next edge.
- R5: Source index 0 has the highest priority and index 13 the lowest. Indices 0..3 are the programmable flags of endpoints 2, 4, 6 and 8. Indices 4..7 are the empty flags and 8..11 the full flags, in the same endpoint order. Index 12 is waveform-complete and index 13 is waveform-wait. Only enabled pending sources take part.
- R6: The vector byte for source index i is 0x80 + 4·i, which gives 0x80 through 0xB4.
- R7: With `autovec_en` = 1, a fetch (`fetch_valid` = 1) from address 0x555 returns the vector byte on `fetch_data` in the same cycle.
- R8: With `autovec_en` = 0, and for any other address such as 0x553 or 0x554, `fetch_data` equals `mem_rdata`.
- R9: The vector byte is captured at the edge where `irq_ack` is high. It stays unchanged until the edge that completes the next 0x555 fetch, even if a higher-priority source becomes pending.
- R10: After reset, all pending and enable bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 14 | One-cycle event pulse per source |
| en_wr | input | 1 | Enable-register write strobe |
| en_wdata | input | 14 | New enable mask |
| clr_wr | input | 1 | Pending-clear write strobe |
| clr_mask | input | 14 | Write-one-to-clear mask |
| autovec_en | input | 1 | Autovector substitution enable |
| irq_ack | input | 1 | CPU interrupt acknowledge pulse |
| fetch_valid | input | 1 | Code fetch in progress this cycle |
| fetch_addr | input | 16 | Code fetch address |
| mem_rdata | input | 8 | Byte read from code memory |
| fetch_data | output | 8 | Byte delivered to the CPU |
| pend_o | output | 14 | Pending register |
| en_o | output | 14 | Enable register |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with its default parameters: fourteen sources, a 16-bit fetch address, base 0x80, step 4, and jump/vector addresses 0x553/0x555. With these values every vector byte from 0x80 to 0xB4 can be reached, as can the lowest-priority source at index 13. The vector address also sits two bytes past the jump address, so the fetches of the opcode and page bytes can be tested to show they are never patched.

// File: rtl/avec_pkg.sv
package avec_pkg;
  typedef logic [7:0] vbyte_t;

  // vector byte for a source position
  function automatic vbyte_t vec_of(input int idx, input vbyte_t base, input int step);
    return base + vbyte_t'(idx * step);
  endfunction
endpackage

// File: rtl/avec_pend_bank.sv
module avec_pend_bank #(
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] live_req
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic clr_hit;
    assign clr_hit = clr_wr & clr_mask[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q[g] <= 1'b0;
      else if (src_pulse[g]) pend_q[g] <= 1'b1;   // set beats clear
      else if (clr_hit)      pend_q[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q[g] <= 1'b0;
      else if (en_wr)  en_q[g] <= en_wdata[g];
    end

    assign live_req[g] = pend_q[g] & en_q[g];
  end
endmodule

// File: rtl/avec_prio_enc.sv
module avec_prio_enc #(
  parameter int NUM_SRC = 14,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/avec_vec_hold.sv
module avec_vec_hold
  import avec_pkg::*;
#(
  parameter int     NUM_SRC  = 14,
  parameter int     ADDR_W   = 16,
  parameter vbyte_t VEC_BASE = 8'h80,
  parameter int     VEC_STEP = 4,
  parameter int     VEC_ADDR = 'h555,
  localparam int    IDX_W    = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [IDX_W-1:0]  idx,
  input  logic              irq_ack,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output vbyte_t            vec_q,
  output logic              vec_locked
);
  vbyte_t live_vec;
  logic   vec_fetch;

  assign live_vec  = vec_of(int'(idx), VEC_BASE, VEC_STEP);
  assign vec_fetch = fetch_valid && (fetch_addr == ADDR_W'(VEC_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q      <= VEC_BASE;
      vec_locked <= 1'b0;
    end else if (irq_ack) begin
      if (any) vec_q <= live_vec;
      vec_locked <= 1'b1;
    end else if (vec_locked) begin
      if (vec_fetch) vec_locked <= 1'b0;
    end else if (any) begin
      vec_q <= live_vec;
    end
  end
endmodule

// File: rtl/avec_fetch_patch.sv
module avec_fetch_patch
  import avec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int VEC_ADDR = 'h555
) (
  input  logic              autovec_en,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  vbyte_t            mem_rdata,
  input  vbyte_t            vec_q,
  output vbyte_t            fetch_data
);
  logic hit;
  assign hit        = autovec_en && fetch_valid && (fetch_addr == ADDR_W'(VEC_ADDR));
  assign fetch_data = hit ? vec_q : mem_rdata;
endmodule

// File: rtl/avec_irq_ctrl.sv
module avec_irq_ctrl
  import avec_pkg::*;
#(
  parameter int     NUM_SRC  = 14,
  parameter int     ADDR_W   = 16,
  parameter vbyte_t VEC_BASE = 8'h80,
  parameter int     VEC_STEP = 4,
  parameter int     VEC_ADDR = 'h555,
  localparam int    IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               autovec_en,
  input  logic               irq_ack,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic [7:0]         mem_rdata,
  output logic [7:0]         fetch_data,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq
);
  logic [NUM_SRC-1:0] live_req;
  logic               any;
  logic [IDX_W-1:0]   idx;
  vbyte_t             vec_q;
  logic               vec_locked;

  avec_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .pend_q(pend_o), .en_q(en_o), .live_req(live_req)
  );

  avec_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .req(live_req), .any(any), .idx(idx)
  );

  avec_vec_hold #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP), .VEC_ADDR(VEC_ADDR)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .any(any), .idx(idx), .irq_ack(irq_ack),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .vec_q(vec_q), .vec_locked(vec_locked)
  );

  avec_fetch_patch #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_patch (
    .autovec_en(autovec_en), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .mem_rdata(mem_rdata), .vec_q(vec_q), .fetch_data(fetch_data)
  );

  assign irq = any;
endmodule

// File: rtl/avec_irq_checker.sv
module avec_irq_checker #(
  parameter int NUM_SRC  = 14,
  parameter int ADDR_W   = 16,
  parameter int VEC_ADDR = 'h555
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_pulse,
  input logic               clr_wr,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic               autovec_en,
  input logic               irq_ack,
  input logic               fetch_valid,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic [7:0]         mem_rdata,
  input logic [7:0]         fetch_data,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [7:0]         vec_q,
  input logic               vec_locked
);
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((pend_o & $past(src_pulse)) == $past(src_pulse))); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend_o & $past(clr_mask & ~src_pulse)) == '0)); // R2

  AST_NO_PATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !autovec_en |-> (fetch_data == mem_rdata)); // R8

  AST_PATCH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (autovec_en && fetch_valid && fetch_addr == ADDR_W'(VEC_ADDR)) |-> (fetch_data == vec_q)); // R7

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_locked && !irq_ack) |=> $stable(vec_q)); // R9
endmodule

bind avec_irq_ctrl avec_irq_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .clr_wr(clr_wr),
  .clr_mask(clr_mask), .autovec_en(autovec_en), .irq_ack(irq_ack),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .mem_rdata(mem_rdata),
  .fetch_data(fetch_data), .pend_o(pend_o), .vec_q(vec_q), .vec_locked(vec_locked)
);

// File: tb/avec_irq_ctrl_test.sv
module avec_irq_ctrl_test;
  localparam int N = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_pulse = '0;
  logic          en_wr = 1'b0;
  logic [N-1:0]  en_wdata = '0;
  logic          clr_wr = 1'b0;
  logic [N-1:0]  clr_mask = '0;
  logic          autovec_en = 1'b0;
  logic          irq_ack = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [15:0]   fetch_addr = '0;
  logic [7:0]    mem_rdata;
  logic [7:0]    fetch_data;
  logic [N-1:0]  pend_o, en_o;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int          exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  assign mem_rdata = fetch_addr[7:0] ^ 8'h5A;   // memory model

  avec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .en_wr(en_wr),
    .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .autovec_en(autovec_en), .irq_ack(irq_ack), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .mem_rdata(mem_rdata), .fetch_data(fetch_data),
    .pend_o(pend_o), .en_o(en_o), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every fetch
  always @(negedge clk) begin
    if (fetch_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard", int'(fetch_data), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(fetch_data) == e, t, int'(fetch_data), e);
      end
    end
  end

  task automatic pulse(input logic [N-1:0] m);
    @(posedge clk); #1 src_pulse = m;
    @(posedge clk); #1 src_pulse = '0;
  endtask
  task automatic set_en(input logic [N-1:0] m);
    @(posedge clk); #1 en_wr = 1'b1; en_wdata = m;
    @(posedge clk); #1 en_wr = 1'b0;
  endtask
  task automatic clr(input logic [N-1:0] m);
    @(posedge clk); #1 clr_wr = 1'b1; clr_mask = m;
    @(posedge clk); #1 clr_wr = 1'b0; clr_mask = '0;
  endtask
  task automatic ack();
    @(posedge clk); #1 irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
  endtask
  // driver: pushes the expectation, then performs the fetch
  task automatic fetch(input logic [15:0] a, input int exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1 fetch_valid = 1'b1; fetch_addr = a;
    @(posedge clk); #1 fetch_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(pend_o == '0, "R10 pend", int'(pend_o), 0);
    check(en_o == '0, "R10 en", int'(en_o), 0);
    check(irq == 1'b0, "R10 irq", int'(irq), 0);
    rst_n = 1'b1;

    // R1: pulse sets pending even when disabled; R4 masking
    pulse(N'(1) << 3);
    check(pend_o[3] == 1'b1, "R1 set", int'(pend_o), 'h8);
    check(irq == 1'b0, "R4 masked", int'(irq), 0);
    set_en('1);
    check(en_o == {N{1'b1}}, "R4 en write", int'(en_o), 'h3FFF);
    check(irq == 1'b1, "R4 raise", int'(irq), 1);
    clr(N'(1) << 3);
    check(pend_o == '0, "R2 clear", int'(pend_o), 0);
    check(irq == 1'b0, "R4 drop", int'(irq), 0);

    // R6/R7: every source vector
    autovec_en = 1'b1;
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i);
      ack();
      fetch(16'h0555, 'h80 + 4 * i, "R6 vector");
      clr(N'(1) << i);
    end

    // R2: partial clear leaves other bits
    pulse(N'('h0030));
    clr(N'('h0010));
    check(pend_o == N'('h0020), "R2 partial", int'(pend_o), 'h20);
    clr(N'('h0020));

    // R5: priority with simultaneous sources
    pulse(N'((1 << 5) | (1 << 9) | (1 << 13) | (1 << 2)));
    ack(); fetch(16'h0555, 'h88, "R5 prio idx2");
    clr(N'(1) << 2);
    ack(); fetch(16'h0555, 'h94, "R5 prio idx5");
    clr(N'(1) << 5);
    set_en({N{1'b1}} & ~(N'(1) << 9));
    ack(); fetch(16'h0555, 'hB4, "R5 masked idx9");
    set_en('1);
    ack(); fetch(16'h0555, 'hA4, "R5 prio idx9");
    clr('1);

    // R9: vector held against a later higher-priority source
    pulse(N'(1) << 10);
    ack();
    pulse(N'(1) << 0);
    fetch(16'h0555, 'hA8, "R9 hold");
    ack();
    fetch(16'h0555, 'h80, "R9 release");

    // R8: no patch at other addresses, nor when disabled
    fetch(16'h0553, 'h53 ^ 'h5A, "R8 jump addr");
    fetch(16'h0554, 'h54 ^ 'h5A, "R8 page addr");
    autovec_en = 1'b0;
    ack();
    fetch(16'h0555, 'h55 ^ 'h5A, "R8 disabled");
    clr('1);

    // R3: set wins over same-cycle clear
    @(posedge clk); #1 src_pulse = N'(1) << 7; clr_wr = 1'b1; clr_mask = N'(1) << 7;
    @(posedge clk); #1 src_pulse = '0; clr_wr = 1'b0; clr_mask = '0;
    check(pend_o[7] == 1'b1, "R3 set wins", int'(pend_o), 'h80);
    check(irq == 1'b1, "R4 irq after R3", int'(irq), 1);

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule